// File: doc/BRIEF.md
# Sampled-Level I2C Transaction Decoder

This block turns a software bit-banged two-wire bus into byte transactions. Software drives the data and clock levels by writing a general-purpose output register. Each such write produces one sample strobe that carries the two levels. The decoder keeps the levels of the previous sample and compares each new sample against them. From that comparison it finds START and STOP conditions and falling clock edges. It does not use the system clock to measure anything on the bus.

The first byte after a START is taken as the address. Its lowest bit selects read or write. In a write transfer, each later byte is handed to a downstream device on a parallel port. In a read transfer, the decoder asks the device for a byte and presents it on the returned data bit, most significant bit first. After each byte it either fetches the next one or reports a negative acknowledge, depending on the level the master drives in the acknowledge slot. Clock stretching, arbitration and multi-master operation are not handled.

All downstream strobes are combinational. Each is high for the single cycle in which the triggering sample strobe is high. Read data from the device is captured in that same cycle.

Top module: `gpio_i2c_decoder`

## Requirements
- R1: After reset the decoder is idle with no address captured. `sda_ret` is 0, all downstream strobes are 0, and the remembered levels of both lines are 1.
- R2: In idle, a sample with data 0 and clock 1, whose previous sample had data 1, arms the decoder. If the next sample is a clock fall (previous clock 1, now 0) with data 0, a byte begins. Any other next sample returns to idle with no strobe.
- R3: While a byte is being written, each clock fall shifts the sampled data level into the byte, most significant bit first. After 8 falls the decoder waits for the acknowledge slot.
- R4: At the clock fall that ends the acknowledge slot of the first byte after START, `dn_start` pulses. `dn_addr` then carries the byte with bit 0 forced to 0, and `dn_rd` carries bit 0 of the byte (1 = read).
- R5: In a write transfer, at the clock fall that ends the acknowledge slot of each later byte, `dn_wr_valid` pulses with the byte on `dn_wr_data`.
- R6: When the address read bit is 1, `dn_rd_req` pulses in the same cycle as `dn_start`, and `dn_rd_data` is captured in that cycle. From then on, `sda_ret` shows the most significant bit of the held byte, and the byte shifts left by one bit on each clock fall.
- R7: `sda_ret` is 0 in every state other than receiving a read bit: idle, armed, writing, the write acknowledge slot, and the master acknowledge slot.
- R8: After 8 read bits, the next clock fall samples the master acknowledge. Data 0 pulses `dn_rd_req` and loads the next byte. Data 1 pulses `dn_nack` and loads nothing. In both cases reading restarts at the most significant bit.
- R9: In any state other than idle, a sample with data 1 and clock 1, whose previous sample had data 0, ends the transfer and returns to idle. `dn_end` pulses only if an address had been captured.
- R10: Line levels presented while `smp_valid` is 0 have no effect on the state, on the remembered levels or on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | One-cycle strobe: an output register write happened |
| smp_sda | input | 1 | Data line level carried by the write |
| smp_scl | input | 1 | Clock line level carried by the write |
| sda_ret | output | 1 | Data level returned to software while reading |
| dn_start | output | 1 | Address captured (strobe) |
| dn_addr | output | 8 | Target address, bit 0 cleared, valid with dn_start |
| dn_rd | output | 1 | Read flag, valid with dn_start |
| dn_wr_valid | output | 1 | Write data byte ready (strobe) |
| dn_wr_data | output | 8 | Write data byte, valid with dn_wr_valid |
| dn_rd_req | output | 1 | Request for the next read byte (strobe) |
| dn_rd_data | input | 8 | Read byte from the device, sampled with dn_rd_req |
| dn_nack | output | 1 | Master refused further read data (strobe) |
| dn_end | output | 1 | Transfer ended by STOP after an address (strobe) |

## Verification
The bench aims at the places where edge detection against the previous sample can go wrong:
- An armed START that is followed by a sample other than a clock fall must fall back to idle. A design that skipped this would decode a spurious address from later bit traffic.
- A STOP before the address byte completes must not emit `dn_end`. An unconditional end would tell the device a transfer happened that never did.
- On reads, the bench follows the returned bit through two fetched bytes and a NACK. An off-by-one in the shift or the bit count would show up as a wrong bit order or a missing request.
- Level changes without the sample strobe are applied mid-byte. A decoder that tracked edges on every clock cycle would shift in extra bits and corrupt the address.

// File: rtl/gdec_pkg.sv
// Shared types for the sampled-level I2C decoder.
// Assumes: nothing beyond IEEE 1800-2017.
package gdec_pkg;

    // Decoder states: idle, armed after START, writing bits, write ack slot,
    // reading bits, master ack slot.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ARM  = 3'd1,
        ST_SEND = 3'd2,
        ST_ACKW = 3'd3,
        ST_RECV = 3'd4,
        ST_MACK = 3'd5
    } gdec_state_t;

    // Byte register operation.
    typedef enum logic [1:0] {
        BUF_HOLD  = 2'd0,
        BUF_SHIFT = 2'd1,
        BUF_LOAD  = 2'd2
    } gdec_bufop_t;

endpackage

// File: rtl/gdec_levels.sv
// Remembers the line levels of the previous sample and reports bus events
// found by comparing the current sample against them.
// Assumes: smp_valid is a one-cycle strobe; levels are only meaningful with it.
module gdec_levels (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_valid,
    input  logic smp_sda,
    input  logic smp_scl,
    output logic scl_fall,
    output logic start_seen,
    output logic stop_seen
);
    logic prev_sda;
    logic prev_scl;

    // Capture the levels of each accepted sample; idle bus is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_sda <= 1'b1;
            prev_scl <= 1'b1;
        end else if (smp_valid) begin
            prev_sda <= smp_sda;
            prev_scl <= smp_scl;
        end
    end

    // Edge and condition detection against the remembered levels.
    always_comb begin
        scl_fall   = smp_valid && prev_scl && !smp_scl;
        start_seen = smp_valid && prev_sda && !smp_sda && smp_scl;
        stop_seen  = smp_valid && !prev_sda && smp_sda && smp_scl;
    end

endmodule

// File: rtl/gdec_shreg.sv
// Byte register shared by the write and read paths: shifts left with a
// new bit at the bottom, or loads a whole byte.
// Assumes: op is decoded by the controller, at most one action per cycle.
module gdec_shreg
    import gdec_pkg::*;
#(
    parameter int W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  gdec_bufop_t op,
    input  logic        bit_in,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] q
);
    // Apply the requested operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            case (op)
                BUF_SHIFT: q <= {q[W-2:0], bit_in};
                BUF_LOAD:  q <= load_val;
                default:   q <= q;
            endcase
        end
    end

endmodule

// File: rtl/gdec_bitcnt.sv
// Counts bit slots within a byte and flags the last one.
// Assumes: clr and inc are never asserted together.
module gdec_bitcnt #(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] TOP = CW'(W - 1);

    logic [CW-1:0] cnt;

    // Advance on each counted bit, wrapping after the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= (cnt == TOP) ? '0 : cnt + 1'b1;
        end
    end

    assign last = (cnt == TOP);

endmodule

// File: rtl/gpio_i2c_decoder.sv
// Decodes software-sampled data/clock levels into I2C byte transactions
// for one downstream device.
// Assumes: single master, no clock stretching; one sample per smp_valid
// strobe; downstream strobes are combinational and dn_rd_data is valid
// in the cycle dn_rd_req is high.
module gpio_i2c_decoder
    import gdec_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic              smp_sda,
    input  logic              smp_scl,
    output logic              sda_ret,
    output logic              dn_start,
    output logic [BYTE_W-1:0] dn_addr,
    output logic              dn_rd,
    output logic              dn_wr_valid,
    output logic [BYTE_W-1:0] dn_wr_data,
    output logic              dn_rd_req,
    input  logic [BYTE_W-1:0] dn_rd_data,
    output logic              dn_nack,
    output logic              dn_end
);
    localparam int MSB = BYTE_W - 1;

    gdec_state_t state, nxt;
    gdec_bufop_t op;
    logic        bit_in;
    logic        cnt_clr, cnt_inc, last_bit;
    logic        scl_fall, start_seen, stop_seen;
    logic        addr_ok, addr_rd;
    logic        addr_set, addr_clr, rd_mode;
    logic [MSB:0] buf_q;

    gdec_levels u_lvl (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .smp_sda(smp_sda), .smp_scl(smp_scl),
        .scl_fall(scl_fall), .start_seen(start_seen), .stop_seen(stop_seen)
    );

    gdec_shreg #(.W(BYTE_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .op(op), .bit_in(bit_in),
        .load_val(dn_rd_data), .q(buf_q)
    );

    gdec_bitcnt #(.W(BYTE_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .last(last_bit)
    );

    // Next state, byte register control and downstream strobes.
    always_comb begin
        nxt         = state;
        op          = BUF_HOLD;
        bit_in      = 1'b0;
        cnt_clr     = 1'b0;
        cnt_inc     = 1'b0;
        addr_set    = 1'b0;
        addr_clr    = 1'b0;
        dn_start    = 1'b0;
        dn_wr_valid = 1'b0;
        dn_rd_req   = 1'b0;
        dn_nack     = 1'b0;
        dn_end      = 1'b0;
        rd_mode     = addr_ok ? addr_rd : buf_q[0];
        if (smp_valid) begin
            case (state)
                ST_IDLE: begin
                    if (start_seen) nxt = ST_ARM;
                end
                ST_ARM: begin
                    if (scl_fall && !smp_sda) begin
                        nxt     = ST_SEND;
                        cnt_clr = 1'b1;
                    end else begin
                        nxt      = ST_IDLE;
                        dn_end   = addr_ok;
                        addr_clr = 1'b1;
                    end
                end
                ST_SEND, ST_RECV: begin
                    if (scl_fall) begin
                        op      = BUF_SHIFT;
                        bit_in  = (state == ST_SEND) ? smp_sda : 1'b0;
                        cnt_inc = 1'b1;
                        if (last_bit) nxt = (state == ST_SEND) ? ST_ACKW : ST_MACK;
                    end else if (stop_seen) begin
                        nxt      = ST_IDLE;
                        dn_end   = addr_ok;
                        addr_clr = 1'b1;
                    end
                end
                ST_ACKW: begin
                    if (scl_fall) begin
                        cnt_clr = 1'b1;
                        if (!addr_ok) begin
                            dn_start = 1'b1;
                            addr_set = 1'b1;
                        end else begin
                            dn_wr_valid = 1'b1;
                        end
                        if (rd_mode) begin
                            nxt       = ST_RECV;
                            op        = BUF_LOAD;
                            dn_rd_req = 1'b1;
                        end else begin
                            nxt = ST_SEND;
                        end
                    end else if (stop_seen) begin
                        nxt      = ST_IDLE;
                        dn_end   = addr_ok;
                        addr_clr = 1'b1;
                    end
                end
                ST_MACK: begin
                    if (scl_fall) begin
                        nxt     = ST_RECV;
                        cnt_clr = 1'b1;
                        if (!smp_sda) begin
                            op        = BUF_LOAD;
                            dn_rd_req = 1'b1;
                        end else begin
                            dn_nack = 1'b1;
                        end
                    end else if (stop_seen) begin
                        nxt      = ST_IDLE;
                        dn_end   = addr_ok;
                        addr_clr = 1'b1;
                    end
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // State and captured-address registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            addr_ok <= 1'b0;
            addr_rd <= 1'b0;
        end else begin
            state <= nxt;
            if (addr_set) begin
                addr_ok <= 1'b1;
                addr_rd <= buf_q[0];
            end else if (addr_clr) begin
                addr_ok <= 1'b0;
            end
        end
    end

    assign dn_addr    = {buf_q[MSB:1], 1'b0};
    assign dn_rd      = buf_q[0];
    assign dn_wr_data = buf_q;
    assign sda_ret    = (state == ST_RECV) && buf_q[MSB];

    // R10: without a sample, nothing visible may move.
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(state) && $stable(sda_ret));

    // R6: the fetched byte's top bit is what software reads next.
    assert_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dn_rd_req |=> sda_ret == $past(dn_rd_data[MSB]));

    // R4: an announced address is remembered with its read flag.
    assert_addr_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dn_start |=> addr_ok && (addr_rd == $past(dn_rd)));

    // R9: an end of transfer always leaves the decoder idle.
    assert_end_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dn_end |=> state == ST_IDLE);

    // R8: fetch and refusal are exclusive in a master ack slot.
    assert_ack_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(dn_rd_req && dn_nack));

endmodule

// File: tb/sim_gpio_i2c_decoder.sv
`timescale 1ns/1ps
module sim_gpio_i2c_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_valid = 1'b0;
    logic       smp_sda = 1'b1;
    logic       smp_scl = 1'b1;
    logic       sda_ret, dn_start, dn_rd, dn_wr_valid, dn_rd_req, dn_nack, dn_end;
    logic [7:0] dn_addr, dn_wr_data;
    logic [7:0] rd_byte = 8'h00;

    int n_chk = 0;
    int n_fail = 0;
    logic [10:0] exp_q[$];

    localparam logic [2:0] K_START = 3'd1, K_REQ = 3'd2, K_WR = 3'd3,
                           K_NACK = 3'd4, K_END = 3'd5;

    always #2.5 clk = ~clk;

    gpio_i2c_decoder u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_sda(smp_sda),
        .smp_scl(smp_scl), .sda_ret(sda_ret), .dn_start(dn_start),
        .dn_addr(dn_addr), .dn_rd(dn_rd), .dn_wr_valid(dn_wr_valid),
        .dn_wr_data(dn_wr_data), .dn_rd_req(dn_rd_req), .dn_rd_data(rd_byte),
        .dn_nack(dn_nack), .dn_end(dn_end)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Scoreboard compare of one observed downstream event.
    task automatic pop_cmp(input logic [2:0] kind, input logic [7:0] data);
        string req;
        logic [10:0] e;
        case (kind)
            K_START: req = "R4";
            K_REQ:   req = "R6/R8";
            K_WR:    req = "R5";
            K_NACK:  req = "R8";
            default: req = "R9";
        endcase
        n_chk++;
        if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL %s: actual event %0h expected none", req, {kind, data});
        end else begin
            e = exp_q.pop_front();
            if (e !== {kind, data}) begin
                n_fail++;
                $display("FAIL %s: actual event %0h expected %0h", req, {kind, data}, e);
            end
        end
    endtask

    // Monitor: sample strobes mid-cycle and compare in a fixed order.
    always @(negedge clk) begin
        if (rst_n) begin
            if (dn_start)    pop_cmp(K_START, dn_addr | {7'd0, dn_rd});
            if (dn_rd_req)   pop_cmp(K_REQ, 8'h00);
            if (dn_wr_valid) pop_cmp(K_WR, dn_wr_data);
            if (dn_nack)     pop_cmp(K_NACK, 8'h00);
            if (dn_end)      pop_cmp(K_END, 8'h00);
        end
    end

    task automatic samp(input logic d, input logic c);
        @(posedge clk); #1;
        smp_sda = d; smp_scl = c; smp_valid = 1'b1;
        @(posedge clk); #1;
        smp_valid = 1'b0;
    endtask

    task automatic do_start();
        samp(1, 1); samp(0, 1); samp(0, 0);
    endtask

    task automatic do_stop();
        samp(0, 0); samp(0, 1); samp(1, 1);
    endtask

    task automatic wbit(input logic b);
        samp(b, 0); samp(b, 1); samp(b, 0);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch);
        for (int i = 7; i >= 0; i--) begin
            wbit(b[i]);
            if (glitch) begin
                // R10: level activity without a sample strobe
                @(posedge clk); #1; smp_scl = 1'b1; smp_sda = ~smp_sda;
                @(posedge clk); #1; smp_scl = 1'b0;
                @(posedge clk); #1; smp_sda = b[i];
            end
            chk("R7 sda_ret low while writing", sda_ret, 0);
        end
    endtask

    task automatic ack_slot();
        samp(0, 0); samp(0, 1); samp(0, 0);
    endtask

    task automatic recv_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk);
            chk("R6 read bit", sda_ret, b[i]);
            samp(1, 0); samp(1, 1); samp(1, 0);
        end
        @(negedge clk);
        chk("R7 sda_ret low in master ack slot", sda_ret, 0);
    endtask

    task automatic finish_up();
        @(negedge clk);
        chk("R9 all expected events seen", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 sda_ret", sda_ret, 0);
        chk("R1 strobes", {dn_start, dn_wr_valid, dn_rd_req, dn_nack, dn_end}, 0);

        // Write transfer: R3, R4, R5, R9
        do_start();
        exp_q.push_back({K_START, 8'h34});
        send_byte(8'h34, 0); ack_slot();
        exp_q.push_back({K_WR, 8'hA5});
        send_byte(8'hA5, 0); ack_slot();
        exp_q.push_back({K_WR, 8'h3C});
        send_byte(8'h3C, 0); ack_slot();
        exp_q.push_back({K_END, 8'h00});
        do_stop();
        @(negedge clk); chk("R9 queue drained after write", exp_q.size(), 0);

        // Read transfer: R6, R7, R8, R9
        rd_byte = 8'hC6;
        do_start();
        exp_q.push_back({K_START, 8'h35});
        exp_q.push_back({K_REQ, 8'h00});
        send_byte(8'h35, 0); ack_slot();
        recv_byte(8'hC6);
        rd_byte = 8'h5B;
        exp_q.push_back({K_REQ, 8'h00});
        ack_slot();
        recv_byte(8'h5B);
        exp_q.push_back({K_NACK, 8'h00});
        samp(1, 0); samp(1, 1); samp(1, 0);
        @(negedge clk); chk("R8 after nack reading restarts at zeroed byte", sda_ret, 0);
        exp_q.push_back({K_END, 8'h00});
        do_stop();
        @(negedge clk); chk("R8 queue drained after read", exp_q.size(), 0);

        // R2: armed START not followed by a clock fall returns to idle
        samp(1, 1); samp(0, 1); samp(0, 1);
        send_byte(8'h34, 0); ack_slot();
        do_stop();
        @(negedge clk); chk("R2 no event after aborted start", exp_q.size(), 0);

        // R9: STOP before the address completes gives no end strobe
        do_start();
        wbit(1); wbit(0); wbit(1);
        do_stop();
        @(negedge clk); chk("R9 no end without address", exp_q.size(), 0);

        // R10: levels without a strobe are ignored, including mid-byte
        @(posedge clk); #1; smp_sda = 1'b0; smp_scl = 1'b1;
        @(posedge clk); #1; smp_scl = 1'b0;
        @(posedge clk); #1; smp_sda = 1'b1;
        @(negedge clk);
        chk("R10 no strobe from unsampled levels",
            {dn_start, dn_wr_valid, dn_rd_req, dn_nack, dn_end}, 0);
        samp(0, 1); samp(0, 0);
        exp_q.push_back({K_START, 8'h20});
        send_byte(8'h20, 1); ack_slot();
        exp_q.push_back({K_END, 8'h00});
        do_stop();
        @(negedge clk); chk("R10 glitch-free address decoded", exp_q.size(), 0);

        finish_up();
    end

endmodule